// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch will be taken by combining two direction predictors and a per-branch selector. The first component is a bimodal table of 2-bit saturating counters, addressed only by the low word-address bits of the branch PC. The second component is a table of 2-bit saturating counters addressed by those same PC bits XORed with a global history of recent branch outcomes. A third table of 2-bit counters, also addressed by the PC alone, picks which component supplies the final answer for each branch.

The fetch side presents a PC once per cycle. One cycle later the block returns the final direction, which component was selected, and the raw prediction of each component. The fetch unit carries the two component predictions along with the branch. When the branch resolves, it returns them on the training port together with the PC and the real outcome. Training updates both component tables. It moves the chooser only when the two components disagreed, and then shifts the outcome into the global history.

Top module: `tourney_pred`

## Requirements
- R1: While `rst` is high and in the cycle after it, `pred_valid` is 0. After reset every chooser counter is 0, so the bimodal side is selected. Every component counter is 1 (weakly not taken), so every lookup returns 0 on `pred_taken`, `pred_sel_corr`, `pred_bim` and `pred_corr` until training occurs.
- R2: A lookup with `fetch_valid` high in cycle t sets `pred_valid` high in cycle t+1. Without a lookup, `pred_valid` is low and the four prediction outputs hold their last values.
- R3: The bimodal counter used is entry `fetch_pc_lo` (or `train_pc_lo`). A component predicts taken when bit 1 of its counter is set (counter value 2 or 3).
- R4: The correlated counter used is entry `pc_lo XOR history`, with the history zero-extended to the index width. It uses the same taken rule as R3.
- R5: The history shifts left by one on each training event and the new outcome enters bit 0. Training and lookups use the history value from before that shift.
- R6: A chooser counter of 0 or 1 selects the bimodal prediction, and 2 or 3 selects the correlated prediction. `pred_taken` equals the selected component's prediction.
- R7: The chooser entry at `train_pc_lo` changes only when `train_bim_pred` differs from `train_corr_pred`. It increments when `train_corr_pred` equals `train_taken` and decrements otherwise, saturating at 0 and 3.
- R8: Every training event updates both component counters, whichever component was selected. A counter increments on taken and decrements on not taken.
- R9: Counters saturate: a counter at 3 stays at 3 on taken, and a counter at 0 stays at 0 on not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Lookup request this cycle |
| fetch_pc_lo | input | IDX_W | Word-address bits of the fetch PC used for indexing |
| pred_valid | output | 1 | Prediction outputs belong to the previous cycle's lookup |
| pred_taken | output | 1 | Final predicted direction |
| pred_sel_corr | output | 1 | 1 when the correlated component was selected |
| pred_bim | output | 1 | Bimodal component prediction |
| pred_corr | output | 1 | Correlated component prediction |
| train_valid | input | 1 | A conditional branch has resolved |
| train_pc_lo | input | IDX_W | Word-address bits of the resolved branch PC |
| train_taken | input | 1 | Actual outcome |
| train_bim_pred | input | 1 | Bimodal prediction made at fetch for this branch |
| train_corr_pred | input | 1 | Correlated prediction made at fetch for this branch |

## Verification
The hardest case to reach from the ports is a branch whose chooser has moved over to the correlated side. That requires the two components to disagree repeatedly while the correlated one is right. The stimulus reaches it in two ways. First, it drives disagreeing component predictions straight onto the training port, which walks a chooser entry up and back down in a few events. Second, it runs a long mixed branch stream that includes a branch whose outcome copies the previous branch's outcome. The history-indexed table learns that branch while the bimodal table cannot, and a reference model tracks every counter so that each lookup is compared exactly.

// File: rtl/tp_pkg.sv
package tp_pkg;
  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_MIN     = 2'd0;
  localparam ctr_t CTR_MAX     = 2'd3;
  localparam ctr_t CTR_WEAK_NT = 2'd1;

  // Saturating step of a 2-bit counter toward taken (up) or not taken.
  function automatic ctr_t ctr_step(input ctr_t c, input logic up);
    if (up)
      return (c == CTR_MAX) ? c : c + 2'd1;
    else
      return (c == CTR_MIN) ? c : c - 2'd1;
  endfunction

  // Counter reads as taken / as correlated-selected in its upper half.
  function automatic logic ctr_high(input ctr_t c);
    return c[1];
  endfunction
endpackage

// File: rtl/tp_index_gen.sv
module tp_index_gen #(
  parameter int IDX_W  = 6,
  parameter int HIST_W = 4
) (
  input  logic [IDX_W-1:0]  pc_lo,
  input  logic [HIST_W-1:0] hist,
  output logic [IDX_W-1:0]  bim_idx,
  output logic [IDX_W-1:0]  cor_idx
);
  logic [IDX_W-1:0] hist_ext;

  always_comb begin
    hist_ext = '0;
    hist_ext[HIST_W-1:0] = hist;
  end

  assign bim_idx = pc_lo;
  assign cor_idx = pc_lo ^ hist_ext;
endmodule

// File: rtl/tp_ctr_table.sv
module tp_ctr_table
  import tp_pkg::*;
#(
  parameter int   IDX_W = 6,
  parameter ctr_t INIT  = CTR_WEAK_NT
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t mem [DEPTH];

  // Write port: read-modify-write of one counter per training event.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= INIT;
    end else if (wr_en) begin
      mem[wr_idx] <= ctr_step(mem[wr_idx], wr_up);
    end
  end

  // Registered lookup port; holds its value when not enabled.
  always_ff @(posedge clk) begin
    if (rst)        rd_ctr <= INIT;
    else if (rd_en) rd_ctr <= mem[rd_idx];
  end
endmodule

// File: rtl/tp_ghist.sv
module tp_ghist #(
  parameter int HIST_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic              taken,
  output logic [HIST_W-1:0] hist
);
  always_ff @(posedge clk) begin
    if (rst)      hist <= '0;
    else if (upd) hist <= {hist[HIST_W-2:0], taken};
  end
endmodule

// File: rtl/tourney_pred.sv
module tourney_pred
  import tp_pkg::*;
#(
  parameter int IDX_W  = 6,
  parameter int HIST_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fetch_valid,
  input  logic [IDX_W-1:0] fetch_pc_lo,
  output logic             pred_valid,
  output logic             pred_taken,
  output logic             pred_sel_corr,
  output logic             pred_bim,
  output logic             pred_corr,
  input  logic             train_valid,
  input  logic [IDX_W-1:0] train_pc_lo,
  input  logic             train_taken,
  input  logic             train_bim_pred,
  input  logic             train_corr_pred
);
  logic [HIST_W-1:0] ghr;
  logic [IDX_W-1:0]  f_bidx, f_cidx, t_bidx, t_cidx;
  ctr_t              bim_ctr, cor_ctr, cho_ctr;
  logic              cho_wr, cho_up;

  tp_index_gen #(.IDX_W(IDX_W), .HIST_W(HIST_W)) i_fetch_ix (
    .pc_lo(fetch_pc_lo), .hist(ghr), .bim_idx(f_bidx), .cor_idx(f_cidx)
  );

  tp_index_gen #(.IDX_W(IDX_W), .HIST_W(HIST_W)) i_train_ix (
    .pc_lo(train_pc_lo), .hist(ghr), .bim_idx(t_bidx), .cor_idx(t_cidx)
  );

  tp_ctr_table #(.IDX_W(IDX_W), .INIT(CTR_WEAK_NT)) i_bim_tab (
    .clk(clk), .rst(rst),
    .rd_en(fetch_valid), .rd_idx(f_bidx), .rd_ctr(bim_ctr),
    .wr_en(train_valid), .wr_idx(t_bidx), .wr_up(train_taken)
  );

  tp_ctr_table #(.IDX_W(IDX_W), .INIT(CTR_WEAK_NT)) i_cor_tab (
    .clk(clk), .rst(rst),
    .rd_en(fetch_valid), .rd_idx(f_cidx), .rd_ctr(cor_ctr),
    .wr_en(train_valid), .wr_idx(t_cidx), .wr_up(train_taken)
  );

  assign cho_wr = train_valid && (train_bim_pred != train_corr_pred);
  assign cho_up = (train_corr_pred == train_taken);

  tp_ctr_table #(.IDX_W(IDX_W), .INIT(CTR_MIN)) i_cho_tab (
    .clk(clk), .rst(rst),
    .rd_en(fetch_valid), .rd_idx(f_bidx), .rd_ctr(cho_ctr),
    .wr_en(cho_wr), .wr_idx(t_bidx), .wr_up(cho_up)
  );

  tp_ghist #(.HIST_W(HIST_W)) i_ghist (
    .clk(clk), .rst(rst), .upd(train_valid), .taken(train_taken), .hist(ghr)
  );

  always_ff @(posedge clk) begin
    if (rst) pred_valid <= 1'b0;
    else     pred_valid <= fetch_valid;
  end

  assign pred_bim      = ctr_high(bim_ctr);
  assign pred_corr     = ctr_high(cor_ctr);
  assign pred_sel_corr = ctr_high(cho_ctr);
  assign pred_taken    = pred_sel_corr ? pred_corr : pred_bim;
endmodule

// File: rtl/tourney_pred_chk.sv
module tourney_pred_chk #(
  parameter int HIST_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              fetch_valid,
  input logic              pred_valid,
  input logic              pred_taken,
  input logic              pred_sel_corr,
  input logic              pred_bim,
  input logic              pred_corr,
  input logic              train_valid,
  input logic              train_taken,
  input logic [HIST_W-1:0] ghr
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !pred_valid && !pred_sel_corr);

  // R2
  lookup_valid_chk: assert property (@(posedge clk) disable iff (rst)
    fetch_valid |=> pred_valid);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid |=> !pred_valid && $stable(pred_taken) && $stable(pred_sel_corr)
                     && $stable(pred_bim) && $stable(pred_corr));

  // R6
  agree_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (pred_valid && pred_bim == pred_corr) |-> pred_taken == pred_bim);

  // R5
  hist_shift_chk: assert property (@(posedge clk) disable iff (rst)
    train_valid |=> ghr[0] == $past(train_taken));

  // R5
  hist_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !train_valid |=> $stable(ghr));
endmodule

bind tourney_pred tourney_pred_chk #(.HIST_W(HIST_W)) i_tourney_pred_chk (
  .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .pred_valid(pred_valid),
  .pred_taken(pred_taken), .pred_sel_corr(pred_sel_corr), .pred_bim(pred_bim),
  .pred_corr(pred_corr), .train_valid(train_valid), .train_taken(train_taken),
  .ghr(ghr)
);

// File: tb/test_tourney_pred.sv
module test_tourney_pred;
  localparam int CLK_PERIOD = 10;
  localparam int IDX_W  = 6;
  localparam int HIST_W = 4;
  localparam int DEPTH  = 1 << IDX_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             fetch_valid = 1'b0;
  logic [IDX_W-1:0] fetch_pc_lo = '0;
  logic             pred_valid, pred_taken, pred_sel_corr, pred_bim, pred_corr;
  logic             train_valid = 1'b0;
  logic [IDX_W-1:0] train_pc_lo = '0;
  logic             train_taken = 1'b0;
  logic             train_bim_pred = 1'b0;
  logic             train_corr_pred = 1'b0;

  int checks = 0;
  int errors = 0;

  // Reference state computed from the requirements.
  int m_bim [DEPTH];
  int m_cor [DEPTH];
  int m_cho [DEPTH];
  int m_hist;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  tourney_pred #(.IDX_W(IDX_W), .HIST_W(HIST_W)) i_tourney_pred (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_pc_lo(fetch_pc_lo),
    .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_sel_corr(pred_sel_corr),
    .pred_bim(pred_bim), .pred_corr(pred_corr), .train_valid(train_valid),
    .train_pc_lo(train_pc_lo), .train_taken(train_taken),
    .train_bim_pred(train_bim_pred), .train_corr_pred(train_corr_pred)
  );

  function automatic int sat(input int c, input bit up);
    if (up) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  function automatic int cidx(input int pc);
    return (pc ^ m_hist) % DEPTH;
  endfunction

  task automatic check(input string req, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Lookup; outputs are sampled on the falling edge after the capturing edge.
  task automatic lookup(input int pc, input string req, output bit bp, output bit cp);
    int eb, ec, es, et;
    eb = (m_bim[pc] >= 2) ? 1 : 0;
    ec = (m_cor[cidx(pc)] >= 2) ? 1 : 0;
    es = (m_cho[pc] >= 2) ? 1 : 0;
    et = es ? ec : eb;
    @(negedge clk);
    fetch_valid = 1'b1;
    fetch_pc_lo = pc[IDX_W-1:0];
    @(negedge clk);
    fetch_valid = 1'b0;
    check("R2", int'(pred_valid), 1, "pred_valid after lookup");
    check(req, int'(pred_bim),  eb, "bimodal prediction");
    check(req, int'(pred_corr), ec, "correlated prediction");
    check(req, int'(pred_sel_corr), es, "selection");
    check(req, int'(pred_taken), et, "final prediction");
    bp = pred_bim;
    cp = pred_corr;
  endtask

  task automatic train(input int pc, input bit tk, input bit bp, input bit cp);
    @(negedge clk);
    train_valid = 1'b1;
    train_pc_lo = pc[IDX_W-1:0];
    train_taken = tk;
    train_bim_pred = bp;
    train_corr_pred = cp;
    @(negedge clk);
    train_valid = 1'b0;
    // R8: both components; R7: chooser only on disagreement; R5: history last.
    m_bim[pc] = sat(m_bim[pc], tk);
    m_cor[cidx(pc)] = sat(m_cor[cidx(pc)], tk);
    if (bp != cp) m_cho[pc] = sat(m_cho[pc], cp == tk);
    m_hist = ((m_hist << 1) | int'(tk)) % (1 << HIST_W);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit bp, cp, tk, prev;
    for (int i = 0; i < DEPTH; i++) begin
      m_bim[i] = 1; m_cor[i] = 1; m_cho[i] = 0;
    end
    m_hist = 0;
    prev = 1'b0;

    repeat (3) @(negedge clk);
    check("R1", int'(pred_valid), 0, "pred_valid in reset");
    rst = 1'b0;
    @(negedge clk);
    check("R1", int'(pred_valid), 0, "pred_valid after reset");

    // R1/R3: sweep every entry after reset.
    for (int p = 0; p < DEPTH; p++) lookup(p, "R1", bp, cp);
    @(negedge clk);
    check("R2", int'(pred_valid), 0, "pred_valid idle");

    // R9: saturate bimodal/correlated at 3, then one not-taken keeps taken.
    for (int k = 0; k < 5; k++) train(5, 1'b1, 1'b0, 1'b0);
    lookup(5, "R9", bp, cp);
    check("R9", int'(pred_bim), 1, "bimodal saturated high");
    train(5, 1'b0, 1'b1, 1'b1);
    lookup(5, "R9", bp, cp);
    check("R9", int'(pred_bim), 1, "bimodal 3 to 2 still taken");
    for (int k = 0; k < 5; k++) train(5, 1'b0, 1'b0, 1'b0);
    lookup(5, "R9", bp, cp);
    train(5, 1'b1, 1'b0, 1'b0);
    lookup(5, "R9", bp, cp);
    check("R9", int'(pred_bim), 0, "bimodal 0 to 1 still not taken");

    // R7: injected disagreement walks chooser of entry 9 to correlated.
    train(9, 1'b1, 1'b0, 1'b1);
    lookup(9, "R7", bp, cp);
    check("R7", int'(pred_sel_corr), 0, "chooser at 1 selects bimodal");
    train(9, 1'b1, 1'b0, 1'b1);
    lookup(9, "R6", bp, cp);
    check("R7", int'(pred_sel_corr), 1, "chooser at 2 selects correlated");
    train(9, 1'b0, 1'b1, 1'b1);
    train(9, 1'b1, 1'b1, 1'b1);
    lookup(9, "R7", bp, cp);
    check("R7", int'(pred_sel_corr), 1, "agreement leaves chooser");
    train(9, 1'b1, 1'b1, 1'b0);
    lookup(9, "R7", bp, cp);
    check("R7", int'(pred_sel_corr), 0, "bimodal right moves chooser down");

    // R3-R8: mixed stream, four branches with different behaviour.
    for (int i = 0; i < 1200; i++) begin
      int pc;
      pc = 16 + (i % 4) * 5;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (i % 4)
        0: tk = ((i / 4) % 3 == 0);
        1: tk = 1'b1;
        2: tk = lfsr[0];
        default: tk = prev;
      endcase
      lookup(pc, "R4", bp, cp);
      train(pc, tk, bp, cp);
      prev = tk;
    end
    // R6: the copy-previous branch has a chooser state checked at the port.
    lookup(31, "R6", bp, cp);
    check("R6", int'(pred_sel_corr), (m_cho[31] >= 2) ? 1 : 0, "migrated selection");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule